// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns addresses from the local processor bus into 64-bit PCI memory addresses. It holds a bank of programmable windows. Each window has a local base, a power-of-two size from 4 KB to 4 GB set by a mask, a 64-bit PCI base made of a low and a high word, an enable bit and a prefetchable bit. For each request the block finds the lowest-numbered enabled window whose region contains the address. It keeps the offset bits below the window boundary and replaces the bits above the boundary with the PCI base. It also reports whether the access needs a dual address cycle, which is the case when the upper 32 bits of the result are non-zero.

A register port writes the window settings and reads them back. Software programs a window's ranges first and sets its enable bit last. Lookups use a valid/ready handshake on both the request side and the response side, with one register stage between them.

Top module: `owt_xlate`

## Requirements
- R1: After reset, rsp_valid_o is 0, req_ready_o is 1, and every window register reads 0.
- R2: The register address is {window index, select}, with select in bits 1:0. Select 0 is the local base, kept in bits 31:12. Select 1 is the mask/attribute word: mask in bits 31:12, prefetchable in bit 1, enable in bit 0. Select 2 is the PCI low word, kept in bits 31:12. Select 3 is the PCI high word, all 32 bits. A read returns the written value with all unkept bits as 0. An index at or above the window count reads 0 and ignores writes.
- R3: A window matches when it is enabled and the request address agrees with the local base in every bit of 31:12 whose mask bit is 1.
- R4: On a match, output bits 11:0 and every bit of 31:12 whose mask bit is 0 come from the request address. Bits of 31:12 whose mask bit is 1 come from the PCI low word. Bits 63:32 come from the PCI high word.
- R5: A window with enable 0 never matches. When no window matches, rsp_miss_o is 1, and rsp_addr_o, rsp_pref_o and rsp_dac_o are all 0.
- R6: When several enabled windows match, the window with the lowest number decides the result.
- R7: rsp_dac_o is 1 exactly when there is a match and the winning window's PCI high word is non-zero.
- R8: rsp_pref_o carries the prefetchable bit of the winning window.
- R9: A mask of all zeros makes a 4 GB window that matches every address.
- R10: A request accepted on a clock edge produces its response on the next edge. The response stays stable while rsp_ready_o is 0. req_ready_o is 1 only when the output register is empty or is being drained in that cycle.
- R11: A register write to a window that is already enabled affects the next request accepted after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {window, select} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted |
| req_addr_i | input | 32 | Local bus address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_addr_o | output | 64 | Translated PCI address |
| rsp_pref_o | output | 1 | Prefetchable attribute of the winning window |
| rsp_dac_o | output | 1 | Dual address cycle required |
| rsp_miss_o | output | 1 | No enabled window matched |

## Verification
The bench sends addresses that fall inside a 1 MB window with a zero high word and inside a 64 KB window with a non-zero high word. These show that the replaced bits depend on the mask and that the dual-address flag is driven correctly. It sends addresses that miss every window, and addresses that would hit a window with enable 0, to tell a true miss from a match that was wrongly allowed. An address covered both by a low window and by a catch-all 4 GB window shows whether the priority order is correct. A stalled response with a second request waiting, and a rewrite of an enabled window's PCI base, show the handshake timing and when a register write takes effect.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int ADDR_W = 32;
  localparam int PAGE_W = 12;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int PCI_W  = 64;

  typedef enum logic [1:0] {
    SEL_LBASE = 2'd0,
    SEL_MATTR = 2'd1,
    SEL_PLO   = 2'd2,
    SEL_PHI   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [HI_W-1:0]   lbase;
    logic [HI_W-1:0]   mask;
    logic              pref;
    logic              en;
    logic [HI_W-1:0]   plo;
    logic [ADDR_W-1:0] phi;
  } win_cfg_t;
endpackage

// File: rtl/owt_regs.sv
module owt_regs
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2,
  localparam int REG_AW = IDX_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [REG_AW-1:0]           addr_i,
  input  logic [ADDR_W-1:0]           wdata_i,
  output logic [ADDR_W-1:0]           rdata_o,
  output win_cfg_t [NUM_WIN-1:0]      cfg_o
);
  logic [IDX_W-1:0] widx;
  reg_sel_e         sel;

  assign widx = addr_i[REG_AW-1:2];
  assign sel  = reg_sel_e'(addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (widx == IDX_W'(w)) begin
          unique case (sel)
            SEL_LBASE: cfg_o[w].lbase <= wdata_i[ADDR_W-1:PAGE_W];
            SEL_MATTR: begin
              cfg_o[w].mask <= wdata_i[ADDR_W-1:PAGE_W];
              cfg_o[w].pref <= wdata_i[1];
              cfg_o[w].en   <= wdata_i[0];
            end
            SEL_PLO:   cfg_o[w].plo <= wdata_i[ADDR_W-1:PAGE_W];
            SEL_PHI:   cfg_o[w].phi <= wdata_i;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (widx == IDX_W'(w)) begin
        unique case (sel)
          SEL_LBASE: rdata_o = {cfg_o[w].lbase, {PAGE_W{1'b0}}};
          SEL_MATTR: rdata_o = {cfg_o[w].mask, {(PAGE_W-2){1'b0}}, cfg_o[w].pref, cfg_o[w].en};
          SEL_PLO:   rdata_o = {cfg_o[w].plo, {PAGE_W{1'b0}}};
          SEL_PHI:   rdata_o = cfg_o[w].phi;
        endcase
      end
    end
  end
endmodule

// File: rtl/owt_match.sv
module owt_match
  import owt_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              pref_o,
  output logic [PCI_W-1:0]  xaddr_o
);
  logic [HI_W-1:0] page;

  assign page    = addr_i[ADDR_W-1:PAGE_W];
  assign hit_o   = cfg_i.en && (((page ^ cfg_i.lbase) & cfg_i.mask) == '0);
  assign pref_o  = cfg_i.pref;
  // size-aligned swap: masked bits from PCI base, offset from local address
  assign xaddr_o = {cfg_i.phi,
                    (cfg_i.plo & cfg_i.mask) | (page & ~cfg_i.mask),
                    addr_i[PAGE_W-1:0]};
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
  import owt_pkg::*;
#(
  parameter int NUM_WIN  = 3,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int REG_AW  = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_addr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [63:0]       rsp_addr_o,
  output logic              rsp_pref_o,
  output logic              rsp_dac_o,
  output logic              rsp_miss_o
);
  win_cfg_t [NUM_WIN-1:0]            cfg;
  logic [NUM_WIN-1:0]                hit;
  logic [NUM_WIN-1:0]                pref;
  logic [NUM_WIN-1:0][PCI_W-1:0]     xaddr;
  logic                              sel_hit;
  logic                              sel_pref;
  logic [PCI_W-1:0]                  sel_addr;
  logic                              accept;

  owt_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    owt_match u_match (
      .cfg_i   (cfg[g]),
      .addr_i  (req_addr_i),
      .hit_o   (hit[g]),
      .pref_o  (pref[g]),
      .xaddr_o (xaddr[g])
    );
  end

  // lowest index wins: scan downward so it overrides last
  always_comb begin
    sel_hit  = 1'b0;
    sel_pref = 1'b0;
    sel_addr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_hit  = 1'b1;
        sel_pref = pref[i];
        sel_addr = xaddr[i];
      end
    end
  end

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_pref_o  <= 1'b0;
      rsp_dac_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_addr_o  <= sel_addr;
      rsp_pref_o  <= sel_pref;
      rsp_dac_o   <= |sel_addr[PCI_W-1:ADDR_W];
      rsp_miss_o  <= !sel_hit;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [63:0] rsp_addr_o,
  input logic        rsp_pref_o,
  input logic        rsp_dac_o,
  input logic        rsp_miss_o
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_miss_o));

  // R10
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o && rsp_addr_o[11:0] == $past(req_addr_i[11:0]) || rsp_miss_o);

  // R10
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  // R7
  dac_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_miss_o |-> rsp_dac_o == (rsp_addr_o[63:32] != 32'd0));

  // R5
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_miss_o |-> !rsp_dac_o && !rsp_pref_o && rsp_addr_o == 64'd0);
endmodule

bind owt_xlate owt_xlate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_pref_o  (rsp_pref_o),
  .rsp_dac_o   (rsp_dac_o),
  .rsp_miss_o  (rsp_miss_o)
);

// File: tb/owt_xlate_bench.sv
module owt_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [63:0] rsp_addr_o;
  logic        rsp_pref_o;
  logic        rsp_dac_o;
  logic        rsp_miss_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk_i = ~clk_i;

  owt_xlate u_owt_xlate (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o == exp, tag, 64'(reg_rdata_o), 64'(exp));
  endtask

  // one lookup; checks addr, pref, dac, miss
  task automatic lookup(input logic [31:0] a, input logic [63:0] ea, input bit ep,
                        input bit ed, input bit em, input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; rsp_ready_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o && rsp_addr_o == ea && rsp_pref_o == ep && rsp_dac_o == ed && rsp_miss_o == em,
          tag, rsp_addr_o, ea);
  endtask

  task automatic t_reset;
    check(!rsp_valid_o && req_ready_o, "R1 handshake idle", 64'({rsp_valid_o, req_ready_o}), 64'h1);
    reg_chk(4'h1, 32'h0, "R1 mattr w0 zero");
    reg_chk(4'h7, 32'h0, "R1 phi w1 zero");
  endtask

  task automatic t_readback;
    reg_wr(4'h0, 32'h4000_0ABC);
    reg_chk(4'h0, 32'h4000_0000, "R2 lbase low bits zero");
    reg_wr(4'h1, 32'hFFF0_0FFE);
    reg_chk(4'h1, 32'hFFF0_0002, "R2 mattr layout");
    reg_wr(4'h2, 32'h8000_0123);
    reg_chk(4'h2, 32'h8000_0000, "R2 plo low bits zero");
    reg_wr(4'h3, 32'h0000_0000);
    reg_wr(4'hB, 32'hDEAD_BEEF);
    reg_chk(4'hB, 32'hDEAD_BEEF, "R2 phi full word");
    reg_wr(4'hB, 32'h0);
    reg_wr(4'hF, 32'h1234_5678);
    reg_chk(4'hF, 32'h0, "R2 absent window reads zero");
  endtask

  task automatic t_basic;
    // w0: 1 MB at 0x4000_0000 -> PCI 0x8000_0000, prefetchable, enabled
    reg_wr(4'h1, 32'hFFF0_0003);
    lookup(32'h4001_2345, 64'h0000_0000_8001_2345, 1'b1, 1'b0, 1'b0, "R3 R4 R8 1MB hit");
    lookup(32'h400F_FFFF, 64'h0000_0000_800F_FFFF, 1'b1, 1'b0, 1'b0, "R4 top of window");
  endtask

  task automatic t_miss;
    // w1 programmed for 0x5000_0000 but left disabled
    reg_wr(4'h4, 32'h5000_0000);
    reg_wr(4'h6, 32'h1234_0000);
    reg_wr(4'h7, 32'h0000_0001);
    reg_wr(4'h5, 32'hFFFF_0000);
    lookup(32'h5000_ABCD, 64'h0, 1'b0, 1'b0, 1'b1, "R5 disabled window misses");
    lookup(32'h4010_0000, 64'h0, 1'b0, 1'b0, 1'b1, "R5 just past window misses");
  endtask

  task automatic t_dac;
    reg_wr(4'h5, 32'hFFFF_0001);
    lookup(32'h5000_ABCD, 64'h0000_0001_1234_ABCD, 1'b0, 1'b1, 1'b0, "R7 R4 64KB hit high word");
    lookup(32'h5001_0000, 64'h0, 1'b0, 1'b0, 1'b1, "R3 outside 64KB");
  endtask

  task automatic t_priority;
    // w2: 4 GB catch-all, PCI base 0, prefetchable
    reg_wr(4'h8, 32'h0);
    reg_wr(4'hA, 32'h0);
    reg_wr(4'h9, 32'h0000_0003);
    lookup(32'h7000_0010, 64'h0000_0000_7000_0010, 1'b1, 1'b0, 1'b0, "R9 catch-all matches");
    lookup(32'h4000_0010, 64'h0000_0000_8000_0010, 1'b1, 1'b0, 1'b0, "R6 w0 beats w2");
    lookup(32'h5000_0004, 64'h0000_0001_1234_0004, 1'b0, 1'b1, 1'b0, "R6 w1 beats w2");
  endtask

  task automatic t_backpressure;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h4000_0100; rsp_ready_i = 1'b0;
    @(negedge clk_i);
    check(rsp_valid_o && !req_ready_o, "R10 stalled rsp blocks req",
          64'({rsp_valid_o, req_ready_o}), 64'h2);
    req_addr_i = 32'h7000_0200;
    @(negedge clk_i);
    check(rsp_valid_o && rsp_addr_o == 64'h8000_0100, "R10 rsp held", rsp_addr_o, 64'h8000_0100);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o && rsp_addr_o == 64'h7000_0200, "R10 drain and accept same edge",
          rsp_addr_o, 64'h7000_0200);
    @(negedge clk_i);
    check(!rsp_valid_o, "R10 empty after drain", 64'(rsp_valid_o), 64'h0);
  endtask

  task automatic t_reprogram;
    reg_wr(4'h2, 32'hC000_0000);
    lookup(32'h4000_0200, 64'h0000_0000_C000_0200, 1'b1, 1'b0, 1'b0, "R11 new PCI base live");
    reg_wr(4'h1, 32'hFFF0_0002);
    lookup(32'h4000_0200, 64'h0000_0000_4000_0200, 1'b1, 1'b0, 1'b0, "R11 R5 disable falls to w2");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_readback();
    t_basic();
    t_miss();
    t_dac();
    t_priority();
    t_backpressure();
    t_reprogram();
    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule